// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh and Initialization Scheduler

This block keeps an asynchronous, multiplexed-address DRAM alive on behalf of a memory controller. After reset it first waits out the power-up settling time. It then runs a fixed number of initialization refresh cycles and only after that raises `initDone`. From then on a free-running interval timer makes a refresh due often enough that every row is refreshed within the retention period.

The scheduler shares the DRAM strobes with an access engine. The engine asks for the memory with `accReq` and owns it while `accGnt` is high. A refresh that falls due during an access is not dropped: up to `MAX_OWED` overdue refreshes are counted, and once the engine lets go they run back to back. While a refresh runs, `refBusy` selects the scheduler's strobes in the strobe multiplexer. Each refresh is a CAS-before-RAS cycle: CAS# falls first, RAS# follows, both rise together, and a precharge gap follows. WE# is held high for the whole cycle, and the address and data lines are not used. Every delay is a parameter counted in system clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rstN` is low, `rasN`, `casN` and `weN` are high and `accGnt`, `refBusy` and `initDone` are low.
- R2: No refresh strobe activity (a `casN` fall) occurs within the first `PWRUP_CYC` clock cycles after reset is released.
- R3: After power-up, exactly `INIT_REFRESHES` refresh cycles run back to back (start-to-start spacing `T_CSR+T_RAS+T_RP+1`). Then `initDone` rises and stays high until the next reset.
- R4: `accGnt` is never high while `initDone` is low, even if `accReq` is held high from reset.
- R5: Each refresh starts with `casN` falling while `rasN` is high, and `refBusy` rising in the same cycle. `rasN` falls exactly `T_CSR` cycles later.
- R6: `rasN` stays low for exactly `T_RAS` cycles. `casN` stays low during all of that time and rises in the same cycle as `rasN`.
- R7: After `rasN` rises, both strobes stay high for exactly `T_RP` cycles before `refBusy` drops. At least one further cycle passes before the next `casN` fall.
- R8: `weN` is high in every cycle in which `refBusy` is high.
- R9: After initialization, with no access activity, refresh cycles start exactly `REF_INTERVAL` cycles apart.
- R10: Refreshes that fall due while the engine holds the grant are counted, up to `MAX_OWED`; further ones are dropped. Two cycles after `accReq` falls, the counted refreshes start back to back, spaced `T_CSR+T_RAS+T_RP+1` apart. The interval timer keeps its phase throughout.
- R11: A granted access keeps `accGnt` high for as long as `accReq` stays high, and a due refresh waits for it. `accGnt` and `refBusy` are never high together. A refresh held back by an access starts two cycles after `accReq` drops.
- R12: When a refresh becomes owed in the same cycle in which a new `accReq` is first seen, the refresh wins. `accGnt` then rises `T_CSR+T_RAS+T_RP+1` cycles after the refresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| accReq | input | 1 | Access engine request; held high for the whole access |
| accGnt | output | 1 | Access engine owns the DRAM strobes |
| refBusy | output | 1 | Scheduler owns the strobes (mux select) |
| initDone | output | 1 | Power-up wait and initialization refreshes complete |
| rasN | output | 1 | Row strobe, active low, valid while `refBusy` |
| casN | output | 1 | Column strobe, active low, valid while `refBusy` |
| weN | output | 1 | Write enable, active low, held high by the scheduler |

## Verification
Two functions can meet in the same cycle: a refresh falling due and a new access request arriving while the scheduler is idle. The bench predicts the cycle in which the next periodic refresh becomes owed from the observed spacing of earlier refreshes. It then raises `accReq` so that it is first seen either in that very cycle or one cycle earlier. In the first case the refresh must start on schedule and the grant must follow exactly one refresh length plus one cycle later. In the second case the grant must come first and the refresh must start two cycles after the request is withdrawn. A long grant that spans many intervals exercises the overdue counter's saturation and the back-to-back catch-up burst.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_GRANT,
    ST_CSR,
    ST_RASLO,
    ST_PRECH
  } refState_e;

  typedef enum logic [1:0] {
    PH_CSR,
    PH_RAS,
    PH_PRE
  } phaseSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic      loadPhase;
    phaseSel_e phaseSel;
    logic      refDone;
  } refStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic pwrDone;
    logic phaseLast;
    logic needRef;
    logic initDone;
  } refStatus_t;

endpackage

// File: rtl/dram_ref_dp.sv
module dram_ref_dp
  import dram_ref_pkg::*;
#(
  parameter int PWRUP_CYC      = 20000,
  parameter int INIT_REFRESHES = 8,
  parameter int REF_INTERVAL   = 1560,
  parameter int T_CSR          = 1,
  parameter int T_RAS          = 5,
  parameter int T_RP           = 3,
  parameter int MAX_OWED       = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  refStrobe_t strb,
  output refStatus_t stat
);

  localparam int PW_W   = $clog2(PWRUP_CYC + 1);
  localparam int IV_W   = $clog2(REF_INTERVAL);
  localparam int PH_MAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                          : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int IN_W   = $clog2(INIT_REFRESHES + 1);
  localparam int OW_W   = $clog2(MAX_OWED + 1);

  logic [PW_W-1:0] pwrCnt;
  logic [IV_W-1:0] intCnt;
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLoad;
  logic [IN_W-1:0] initLeft;
  logic [OW_W-1:0] owed;
  logic [OW_W-1:0] owedNext;
  logic            pwrDone;
  logic            initDone;
  logic            tick;
  logic            decOwed;

  // power-up settling counter
  assign pwrDone = (pwrCnt == PW_W'(PWRUP_CYC));

  always_ff @(posedge clk) begin
    if (!rstN)         pwrCnt <= '0;
    else if (!pwrDone) pwrCnt <= pwrCnt + 1'b1;
  end

  // phase length timer shared by the three refresh phases
  always_comb begin
    unique case (strb.phaseSel)
      PH_CSR:  phaseLoad = PH_W'(T_CSR - 1);
      PH_RAS:  phaseLoad = PH_W'(T_RAS - 1);
      default: phaseLoad = PH_W'(T_RP - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                phaseCnt <= '0;
    else if (strb.loadPhase)  phaseCnt <= phaseLoad;
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - 1'b1;
  end

  // initialization refresh budget
  always_ff @(posedge clk) begin
    if (!rstN)                               initLeft <= IN_W'(INIT_REFRESHES);
    else if (strb.refDone && initLeft != '0) initLeft <= initLeft - 1'b1;
  end

  assign initDone = (initLeft == '0);

  // retention interval timer, free running once initialized
  assign tick = initDone && (intCnt == IV_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !initDone) intCnt <= '0;
    else if (tick)          intCnt <= '0;
    else                    intCnt <= intCnt + 1'b1;
  end

  // overdue refresh counter, saturating
  assign decOwed = strb.refDone && initDone && (owed != '0);

  always_comb begin
    owedNext = owed;
    if (tick && !decOwed) begin
      if (owed != OW_W'(MAX_OWED)) owedNext = owed + 1'b1;
    end else if (!tick && decOwed) begin
      owedNext = owed - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) owed <= '0;
    else       owed <= owedNext;
  end

  assign stat.pwrDone   = pwrDone;
  assign stat.phaseLast = (phaseCnt == '0);
  assign stat.needRef   = initDone ? (owed != '0) : 1'b1;
  assign stat.initDone  = initDone;

endmodule

// File: rtl/dram_ref_ctl.sv
module dram_ref_ctl
  import dram_ref_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accReq,
  input  refStatus_t stat,
  output refStrobe_t strb,
  output logic       accGnt,
  output logic       refBusy,
  output logic       rasN,
  output logic       casN,
  output logic       weN
);

  refState_e state;
  refState_e nxt;

  always_comb begin
    nxt  = state;
    strb = '{loadPhase: 1'b0, phaseSel: PH_CSR, refDone: 1'b0};
    unique case (state)
      ST_PWRUP: if (stat.pwrDone) nxt = ST_IDLE;
      ST_IDLE: begin
        if (stat.needRef) begin
          nxt            = ST_CSR;
          strb.loadPhase = 1'b1;
          strb.phaseSel  = PH_CSR;
        end else if (accReq && stat.initDone) begin
          nxt = ST_GRANT;
        end
      end
      ST_GRANT: if (!accReq) nxt = ST_IDLE;
      ST_CSR: begin
        if (stat.phaseLast) begin
          nxt            = ST_RASLO;
          strb.loadPhase = 1'b1;
          strb.phaseSel  = PH_RAS;
        end
      end
      ST_RASLO: begin
        if (stat.phaseLast) begin
          nxt            = ST_PRECH;
          strb.loadPhase = 1'b1;
          strb.phaseSel  = PH_PRE;
        end
      end
      ST_PRECH: begin
        if (stat.phaseLast) begin
          nxt          = ST_IDLE;
          strb.refDone = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // state and strobes registered together so the pins never glitch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PWRUP;
      accGnt  <= 1'b0;
      refBusy <= 1'b0;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      weN     <= 1'b1;
    end else begin
      state   <= nxt;
      accGnt  <= (nxt == ST_GRANT);
      refBusy <= (nxt == ST_CSR) || (nxt == ST_RASLO) || (nxt == ST_PRECH);
      rasN    <= (nxt != ST_RASLO);
      casN    <= !((nxt == ST_CSR) || (nxt == ST_RASLO));
      weN     <= 1'b1;
    end
  end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int PWRUP_CYC      = 20000,
  parameter int INIT_REFRESHES = 8,
  parameter int REF_INTERVAL   = 1560,
  parameter int T_CSR          = 1,
  parameter int T_RAS          = 5,
  parameter int T_RP           = 3,
  parameter int MAX_OWED       = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic accReq,
  output logic accGnt,
  output logic refBusy,
  output logic initDone,
  output logic rasN,
  output logic casN,
  output logic weN
);

  refStrobe_t strb;
  refStatus_t stat;

  dram_ref_dp #(
    .PWRUP_CYC     (PWRUP_CYC),
    .INIT_REFRESHES(INIT_REFRESHES),
    .REF_INTERVAL  (REF_INTERVAL),
    .T_CSR         (T_CSR),
    .T_RAS         (T_RAS),
    .T_RP          (T_RP),
    .MAX_OWED      (MAX_OWED)
  ) u_dp (
    .clk (clk),
    .rstN(rstN),
    .strb(strb),
    .stat(stat)
  );

  dram_ref_ctl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .accReq (accReq),
    .stat   (stat),
    .strb   (strb),
    .accGnt (accGnt),
    .refBusy(refBusy),
    .rasN   (rasN),
    .casN   (casN),
    .weN    (weN)
  );

  assign initDone = stat.initDone;

endmodule

// File: rtl/dram_ref_chk.sv
module dram_ref_chk #(
  parameter int PWRUP_CYC = 20000,
  parameter int T_CSR     = 1,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3
) (
  input logic clk,
  input logic rstN,
  input logic accGnt,
  input logic refBusy,
  input logic initDone,
  input logic rasN,
  input logic casN,
  input logic weN
);

  int unsigned sinceRst;
  int unsigned csrCnt;
  int unsigned rasLowCnt;
  int unsigned preCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst  <= 0;
      csrCnt    <= 0;
      rasLowCnt <= 0;
      preCnt    <= 0;
    end else begin
      if (sinceRst < PWRUP_CYC) sinceRst <= sinceRst + 1;
      if (rasN && !casN)        csrCnt <= csrCnt + 1;
      else if (rasN)            csrCnt <= 0;
      if (!rasN)                rasLowCnt <= rasLowCnt + 1;
      else                      rasLowCnt <= 0;
      if (refBusy && rasN && casN) preCnt <= preCnt + 1;
      else if (!refBusy)           preCnt <= 0;
    end
  end

  p_pwrup_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> sinceRst >= PWRUP_CYC);

  p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  p_no_early_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    accGnt |-> initDone);

  p_cas_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !casN && $past(!casN) && csrCnt == T_CSR);

  p_cas_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN);

  p_ras_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $rose(casN) && rasLowCnt == T_RAS);

  p_precharge_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refBusy) |-> preCnt == T_RP);

  p_we_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    refBusy |-> weN);

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(accGnt && refBusy));

endmodule

bind dram_refresh_sched dram_ref_chk #(
  .PWRUP_CYC(PWRUP_CYC),
  .T_CSR    (T_CSR),
  .T_RAS    (T_RAS),
  .T_RP     (T_RP)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .accGnt  (accGnt),
  .refBusy (refBusy),
  .initDone(initDone),
  .rasN    (rasN),
  .casN    (casN),
  .weN     (weN)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;

  localparam int PWRUP = 50;
  localparam int NINIT = 8;
  localparam int IVL   = 200;
  localparam int TCSR  = 2;
  localparam int TRAS  = 5;
  localparam int TRP   = 3;
  localparam int MOWED = 8;
  localparam int GAP   = TCSR + TRAS + TRP + 1;

  logic clk = 1'b0;
  logic rstN;
  logic accReq;
  logic accGnt, refBusy, initDone, rasN, casN, weN;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .PWRUP_CYC(PWRUP), .INIT_REFRESHES(NINIT), .REF_INTERVAL(IVL),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .MAX_OWED(MOWED)
  ) u0 (
    .clk(clk), .rstN(rstN), .accReq(accReq), .accGnt(accGnt),
    .refBusy(refBusy), .initDone(initDone), .rasN(rasN), .casN(casN), .weN(weN)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  // scoreboard queue of observed refresh start cycles
  int startQ[$];
  int initStarts = 0;
  int gntRise    = -1;
  bit earlyGnt   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // monitor: samples on the falling edge
  logic prevCas = 1, prevGnt = 0, prevBusy = 0, weLow = 0;
  int csrW = 0, rasW = 0, rpW = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevCas && !casN) begin
        startQ.push_back(cyc);
        if (!initDone) initStarts++;
      end
      if (!prevGnt && accGnt) gntRise = cyc;
      if (accGnt && !initDone) earlyGnt = 1;
      if (refBusy && !casN && rasN) csrW++;
      if (!rasN) rasW++;
      if (refBusy && rasN && casN) rpW++;
      if (refBusy && !weN) weLow = 1;
      if (prevBusy && !refBusy) begin
        chk(csrW == TCSR, "R5 cas-to-ras cycles", csrW, TCSR);
        chk(rasW == TRAS, "R6 ras low cycles", rasW, TRAS);
        chk(rpW == TRP, "R7 precharge cycles", rpW, TRP);
        chk(!weLow, "R8 weN high during refresh", weLow, 0);
        csrW = 0; rasW = 0; rpW = 0; weLow = 0;
      end
      prevCas  = casN;
      prevGnt  = accGnt;
      prevBusy = refBusy;
    end
  end

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int s0, p2, p3;
    rstN   = 1'b0;
    accReq = 1'b1;  // held from reset to probe R4
    repeat (4) @(negedge clk);
    #1;
    chk(rasN, "R1 rasN reset", rasN, 1);
    chk(casN, "R1 casN reset", casN, 1);
    chk(weN, "R1 weN reset", weN, 1);
    chk(!accGnt, "R1 accGnt reset", accGnt, 0);
    chk(!refBusy, "R1 refBusy reset", refBusy, 0);
    chk(!initDone, "R1 initDone reset", initDone, 0);
    rstN = 1'b1;

    while (!initDone) begin @(negedge clk); #1; end
    chk(initStarts == NINIT, "R3 init refresh count", initStarts, NINIT);
    chk(startQ[0] >= PWRUP, "R2 first refresh after power-up wait", startQ[0], PWRUP);
    for (int i = 1; i < NINIT; i++)
      chk(startQ[i] - startQ[i-1] == GAP, "R3 init spacing", startQ[i] - startQ[i-1], GAP);
    chk(!earlyGnt, "R4 no grant before initDone", earlyGnt, 0);

    @(negedge clk); #1;
    chk(accGnt, "R11 grant after init", accGnt, 1);
    repeat (5) @(negedge clk); #1;
    chk(accGnt && initDone, "R11 grant held while requested", accGnt, 1);
    accReq = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk(!accGnt, "R11 grant drops after release", accGnt, 0);
    startQ.delete();

    // periodic spacing
    while (startQ.size() < 2) begin @(negedge clk); #1; end
    chk(startQ[1] - startQ[0] == IVL, "R9 refresh interval", startQ[1] - startQ[0], IVL);
    s0 = startQ[1];

    // long access spanning ten intervals: overdue count saturates
    waitCyc(s0 + 15);
    accReq = 1'b1;
    waitCyc(s0 + 10*IVL + 20);
    chk(accGnt, "R11 grant held over many intervals", accGnt, 1);
    chk(startQ.size() == 2, "R11 no refresh during grant", startQ.size(), 2);
    startQ.delete();
    accReq = 1'b0;
    waitCyc(s0 + 11*IVL + 5);
    chk(startQ.size() == MOWED + 1, "R10 saturated burst plus next periodic",
        startQ.size(), MOWED + 1);
    if (startQ.size() == MOWED + 1) begin
      chk(startQ[0] == s0 + 10*IVL + 22, "R10 burst start after release",
          startQ[0], s0 + 10*IVL + 22);
      for (int i = 1; i < MOWED; i++)
        chk(startQ[i] - startQ[i-1] == GAP, "R10 back-to-back spacing",
            startQ[i] - startQ[i-1], GAP);
      chk(startQ[MOWED] == s0 + 11*IVL, "R10 timer phase kept", startQ[MOWED], s0 + 11*IVL);
    end

    // collision: request first seen in the cycle the refresh becomes owed
    p2 = s0 + 12*IVL;
    startQ.delete();
    waitCyc(p2 - 1);
    accReq = 1'b1;
    waitCyc(p2 + GAP + 3);
    chk(startQ.size() == 1 && startQ[0] == p2, "R12 refresh wins same cycle",
        (startQ.size() > 0) ? startQ[0] : -1, p2);
    chk(gntRise == p2 + GAP, "R12 grant after refresh", gntRise, p2 + GAP);
    accReq = 1'b0;

    // request seen one cycle earlier: grant first, refresh waits
    p3 = p2 + IVL;
    startQ.delete();
    waitCyc(p3 - 2);
    accReq = 1'b1;
    waitCyc(p3 + 5);
    chk(gntRise == p3 - 1, "R11 grant before refresh", gntRise, p3 - 1);
    chk(startQ.size() == 0, "R11 refresh waits for access", startQ.size(), 0);
    accReq = 1'b0;
    waitCyc(p3 + 20);
    chk(startQ.size() == 1 && startQ[0] == p3 + 7, "R11 deferred refresh start",
        (startQ.size() > 0) ? startQ[0] : -1, p3 + 7);
    chk(initDone, "R3 initDone stays high", initDone, 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule